// File: doc/BRIEF.md
# Half-Bridge Fault Coordination Logic

This block is the fault manager shared by the high and low channels of one half-bridge gate driver. Several such drivers, one per phase, share two active-low, wired-AND network lines. The first is a freeze line: while any driver holds it low, every driver keeps its outputs at their previous values. The second is a fault/shutdown line: while it is low, every driver turns both outputs off at once. Each line is modelled as a drive-low output from this block plus a sensed input, which the surrounding wiring combines as a wired-AND.

When either local channel reports desaturation, the block runs a soft turn-off of fixed length and pulls the freeze line low for that time. This keeps a peer phase that shares the short circuit from being hard-stopped in the middle. When the soft turn-off ends, the freeze request is dropped and a fault is latched onto the fault/shutdown line. Only the fault-clear input releases that latched fault. Logic-supply undervoltage and an external low on the fault/shutdown line also force a hard shutdown, but neither is latched. Both are masked while a soft turn-off is running.

The block moves no data stream, so it has no valid/ready interface. Every pin is a plain level-sensitive control or status signal, sampled on the rising clock edge.

Top module: `phase_fault_coord`

## Requirements
- R1: `sync_sense_n` and `flt_sense_n` each pass through a two-flop synchronizer. `hold` is 1 exactly when the synchronized freeze line is low, so it follows a change on `sync_sense_n` after two rising edges. It does not depend on the command or desaturation inputs.
- R2: A desaturation request (`desat_hi_req` or `desat_lo_req` = 1) starts a soft turn-off at the next edge when no turn-off is running and no fault is latched. This holds even while `hold` is 1. `ssd_active` goes to 1, and `ssd_hi`/`ssd_lo` name the side that tripped. The high side wins when both sides request in the same cycle.
- R3: A soft turn-off lasts exactly `SSD_CYCLES` cycles. On the edge where `ssd_active` falls, `fault_latched` rises and `flt_drv_low` goes to 1. Both stay at 1 until they are cleared as in R4.
- R4: `flt_clr` = 1 clears `fault_latched` at the next edge, provided the synchronized freeze line is high. A fault that becomes latched on the same edge takes priority over the clear.
- R5: `uv_logic` = 1 drives `flt_drv_low` and `hard_sd` to 1 for as long as it lasts. Nothing is latched, so both return to 0 once it clears, unless a fault is latched.
- R6: A synchronized low on the fault/shutdown line sets `hard_sd` to 1. `flt_clr` has no effect on this condition.
- R7: While `ssd_active` = 1, `hard_sd` is 0 and `flt_drv_low` is 0, whatever the state of `uv_logic` and the fault/shutdown line. New desaturation requests are ignored while a turn-off runs or a fault is latched.
- R8: `sync_drv_low` equals 1 only during the block's own soft turn-off. It releases by itself when the turn-off ends, without any `flt_clr`.
- R9: `flt_clr` = 1 while the synchronized freeze line is low is ignored. `clr_violation` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desat_hi_req | input | 1 | Desaturation detected on the high-side channel |
| desat_lo_req | input | 1 | Desaturation detected on the low-side channel |
| uv_logic | input | 1 | Logic-supply undervoltage flag |
| flt_clr | input | 1 | Active-high fault clear |
| sync_sense_n | input | 1 | Sensed level of the shared freeze line (0 = asserted) |
| flt_sense_n | input | 1 | Sensed level of the shared fault/shutdown line (0 = asserted) |
| sync_drv_low | output | 1 | 1 pulls the shared freeze line low |
| flt_drv_low | output | 1 | 1 pulls the shared fault/shutdown line low |
| hold | output | 1 | Freeze both outputs at their previous values |
| hard_sd | output | 1 | Force both outputs off immediately |
| fault_latched | output | 1 | Latched desaturation fault |
| ssd_active | output | 1 | Soft turn-off in progress |
| ssd_hi | output | 1 | Soft turn-off is on the high side |
| ssd_lo | output | 1 | Soft turn-off is on the low side |
| clr_violation | output | 1 | A fault clear arrived while the freeze line was low |

## Verification
Three instances share one wired-AND freeze line and one fault/shutdown line. A directed sequence trips one phase and checks that its peers freeze and then shut down. It also checks that a clear issued during the freeze is rejected, and that a later clear is accepted. Random stretches then mix desaturation on both sides of all three phases with sparse undervoltage, external shutdown, external freeze and clear pulses. These stretches tell apart the cases that the masking and priority rules separate: a request during a running turn-off, undervoltage during a turn-off, a clear racing with the end of a turn-off, and simultaneous high- and low-side trips. Every output of every instance is compared each cycle against an independent model that includes the two-cycle synchronizer delay.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic {
    SSD_IDLE = 1'b0,
    SSD_RUN  = 1'b1
  } ssd_state_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } side_t;
endpackage

// File: rtl/pfc_line_sync.sv
module pfc_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Released (high) is the idle level of both network lines.
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfc_ssd_seq.sv
module pfc_ssd_seq
  import pfc_pkg::*;
#(
  parameter int SSD_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  desat_hi,
  input  logic  desat_lo,
  input  logic  blocked,
  output logic  active,
  output side_t side,
  output logic  done
);
  localparam int CW = $clog2(SSD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SSD_CYCLES - 1);

  ssd_state_t    st;
  logic [CW-1:0] cnt;
  logic          start;

  assign start  = (desat_hi || desat_lo) && (st == SSD_IDLE) && !blocked;
  assign done   = (st == SSD_RUN) && (cnt == '0);
  assign active = (st == SSD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SSD_IDLE;
      cnt  <= '0;
      side <= '0;
    end else if (start) begin
      st      <= SSD_RUN;
      cnt     <= LAST;
      side.hi <= desat_hi;
      side.lo <= !desat_hi;
    end else if (done) begin
      st   <= SSD_IDLE;
      side <= '0;
    end else if (st == SSD_RUN) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_SIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(side) && (active == (side != '0))); // R2
  AST_DESAT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (desat_hi || desat_lo) && !active && !blocked |=> active && (side.hi == $past(desat_hi))); // R2
  AST_RUN_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    active && !done |=> active && $stable(side)); // R7
endmodule

// File: rtl/pfc_fault_latch.sv
module pfc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ssd_done,
  input  logic clr,
  input  logic sync_low,
  output logic latched,
  output logic clr_violation
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched       <= 1'b0;
      clr_violation <= 1'b0;
    end else begin
      if (ssd_done)              latched <= 1'b1;
      else if (clr && !sync_low) latched <= 1'b0;
      clr_violation <= clr && sync_low;
    end
  end

  AST_CLR_BLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    latched && sync_low && clr |=> latched && clr_violation); // R9
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !sync_low && clr && !ssd_done |=> !latched); // R4
  AST_LATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(ssd_done)); // R3
endmodule

// File: rtl/phase_fault_coord.sv
module phase_fault_coord
  import pfc_pkg::*;
#(
  parameter int SSD_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desat_hi_req,
  input  logic desat_lo_req,
  input  logic uv_logic,
  input  logic flt_clr,
  input  logic sync_sense_n,
  input  logic flt_sense_n,
  output logic sync_drv_low,
  output logic flt_drv_low,
  output logic hold,
  output logic hard_sd,
  output logic fault_latched,
  output logic ssd_active,
  output logic ssd_hi,
  output logic ssd_lo,
  output logic clr_violation
);
  localparam int LINES = 2;
  localparam int SYNC_BIT = 1;
  localparam int FLT_BIT  = 0;

  logic [LINES-1:0] sensed;
  logic             sync_low;
  logic             ext_flt_low;
  logic             ssd_done;
  side_t            side;

  pfc_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sync_sense_n, flt_sense_n}),
    .q     (sensed)
  );

  assign sync_low    = !sensed[SYNC_BIT];
  assign ext_flt_low = !sensed[FLT_BIT];

  pfc_ssd_seq #(.SSD_CYCLES(SSD_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .desat_hi (desat_hi_req),
    .desat_lo (desat_lo_req),
    .blocked  (fault_latched),
    .active   (ssd_active),
    .side     (side),
    .done     (ssd_done)
  );

  pfc_fault_latch u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .ssd_done      (ssd_done),
    .clr           (flt_clr),
    .sync_low      (sync_low),
    .latched       (fault_latched),
    .clr_violation (clr_violation)
  );

  assign ssd_hi       = side.hi;
  assign ssd_lo       = side.lo;
  assign sync_drv_low = ssd_active;
  assign hold         = sync_low;
  assign flt_drv_low  = fault_latched || (uv_logic && !ssd_active);
  assign hard_sd      = !ssd_active && (fault_latched || uv_logic || ext_flt_low);

  // Counts edges out of reset so that line-latency checks never look at reset-time history.
  logic [1:0] arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             arm_q <= '0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 1'b1;
  end

  AST_FREEZE_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q != 2'd0 && !sync_sense_n && $past(!sync_sense_n) |=> hold); // R1
  AST_EXT_SD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q != 2'd0 && !flt_sense_n && $past(!flt_sense_n) |=> hard_sd || ssd_active); // R6
  AST_UV_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_logic && !fault_latched |-> !flt_drv_low); // R5
  AST_SSD_MASKS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_active |-> !flt_drv_low && !hard_sd && !fault_latched); // R7
  AST_SYNC_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssd_active) |-> !sync_drv_low && fault_latched); // R8
endmodule

// File: tb/phase_fault_coord_test.sv
module phase_fault_coord_test;
  localparam int N  = 8;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NI-1:0] dh = '0, dl = '0, uv = '0, clr = '0;
  logic          ext_sync = 1'b0, ext_sd = 1'b0;
  logic [NI-1:0] o_sync, o_flt, o_hold, o_hsd, o_lat, o_act, o_hi, o_lo, o_viol;
  logic          sync_line, flt_line;

  assign sync_line = !(|o_sync) && !ext_sync;
  assign flt_line  = !(|o_flt) && !ext_sd;

  phase_fault_coord #(.SSD_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .desat_hi_req(dh[0]), .desat_lo_req(dl[0]),
    .uv_logic(uv[0]), .flt_clr(clr[0]), .sync_sense_n(sync_line), .flt_sense_n(flt_line),
    .sync_drv_low(o_sync[0]), .flt_drv_low(o_flt[0]), .hold(o_hold[0]), .hard_sd(o_hsd[0]),
    .fault_latched(o_lat[0]), .ssd_active(o_act[0]), .ssd_hi(o_hi[0]), .ssd_lo(o_lo[0]),
    .clr_violation(o_viol[0]));
  phase_fault_coord #(.SSD_CYCLES(N)) peer_b (
    .clk(clk), .rst_n(rst_n), .desat_hi_req(dh[1]), .desat_lo_req(dl[1]),
    .uv_logic(uv[1]), .flt_clr(clr[1]), .sync_sense_n(sync_line), .flt_sense_n(flt_line),
    .sync_drv_low(o_sync[1]), .flt_drv_low(o_flt[1]), .hold(o_hold[1]), .hard_sd(o_hsd[1]),
    .fault_latched(o_lat[1]), .ssd_active(o_act[1]), .ssd_hi(o_hi[1]), .ssd_lo(o_lo[1]),
    .clr_violation(o_viol[1]));
  phase_fault_coord #(.SSD_CYCLES(N)) peer_c (
    .clk(clk), .rst_n(rst_n), .desat_hi_req(dh[2]), .desat_lo_req(dl[2]),
    .uv_logic(uv[2]), .flt_clr(clr[2]), .sync_sense_n(sync_line), .flt_sense_n(flt_line),
    .sync_drv_low(o_sync[2]), .flt_drv_low(o_flt[2]), .hold(o_hold[2]), .hard_sd(o_hsd[2]),
    .fault_latched(o_lat[2]), .ssd_active(o_act[2]), .ssd_hi(o_hi[2]), .ssd_lo(o_lo[2]),
    .clr_violation(o_viol[2]));

  // Reference model built from the requirements.
  logic [NI-1:0] m_run, m_hi, m_lo, m_lat, m_viol, m_s1, m_s2, m_f1, m_f2;
  int            m_cnt [NI];
  logic          m_sync_line, m_flt_line;

  assign m_sync_line = !(|m_run) && !ext_sync;
  assign m_flt_line  = !(|(m_lat | (uv & ~m_run))) && !ext_sd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= '0; m_hi <= '0; m_lo <= '0; m_lat <= '0; m_viol <= '0;
      m_s1 <= '1; m_s2 <= '1; m_f1 <= '1; m_f2 <= '1;
      for (int i = 0; i < NI; i++) m_cnt[i] <= 0;
    end else begin
      for (int i = 0; i < NI; i++) begin
        m_s1[i] <= m_sync_line; m_s2[i] <= m_s1[i];
        m_f1[i] <= m_flt_line;  m_f2[i] <= m_f1[i];
        m_viol[i] <= clr[i] && !m_s2[i];
        if (m_run[i] && m_cnt[i] == 0) begin
          m_run[i] <= 1'b0; m_hi[i] <= 1'b0; m_lo[i] <= 1'b0; m_lat[i] <= 1'b1;
        end else begin
          if (m_run[i]) m_cnt[i] <= m_cnt[i] - 1;
          else if ((dh[i] || dl[i]) && !m_lat[i]) begin
            m_run[i] <= 1'b1; m_cnt[i] <= N - 1; m_hi[i] <= dh[i]; m_lo[i] <= !dh[i];
          end
          if (clr[i] && m_s2[i]) m_lat[i] <= 1'b0;
        end
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input int inst, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inst%0d at %0t: got %0b expected %0b", tag, inst, $time, got, exp);
    end
  endtask

  function automatic logic exp_hsd(input int i);
    return !m_run[i] && (m_lat[i] || uv[i] || !m_f2[i]);
  endfunction

  function automatic logic exp_fdrv(input int i);
    return m_lat[i] || (uv[i] && !m_run[i]);
  endfunction

  task automatic check_all();
    for (int i = 0; i < NI; i++) begin
      chk("R1 hold", i, o_hold[i], !m_s2[i]);
      chk("R2 ssd_active", i, o_act[i], m_run[i]);
      chk("R2 ssd_hi", i, o_hi[i], m_hi[i]);
      chk("R2 ssd_lo", i, o_lo[i], m_lo[i]);
      chk("R3 R4 fault_latched", i, o_lat[i], m_lat[i]);
      chk("R5 R7 flt_drv_low", i, o_flt[i], exp_fdrv(i));
      chk("R6 R7 hard_sd", i, o_hsd[i], exp_hsd(i));
      chk("R8 sync_drv_low", i, o_sync[i], m_run[i]);
      chk("R9 clr_violation", i, o_viol[i], m_viol[i]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(negedge clk);
    // Reset state, R1 R3 R8: all outputs quiet.
    check_all();
    rst_n = 1'b1;
    step();
    // Directed: uut high side trips; peers must freeze (R1 R2).
    dh[0] = 1'b1; step(); dh[0] = 1'b0;
    chk("R2 directed start", 0, o_act[0], 1'b1);
    repeat (3) step();
    chk("R1 directed peer freeze", 1, o_hold[1], 1'b1);
    // R7: undervoltage and a lower-side request during the run stay masked.
    uv[0] = 1'b1; dl[0] = 1'b1; step(); uv[0] = 1'b0; dl[0] = 1'b0;
    chk("R7 directed uv masked", 0, o_flt[0], 1'b0);
    while (o_act[0]) step();
    chk("R3 directed latch", 0, o_lat[0], 1'b1);
    chk("R8 directed sync release", 0, o_sync[0], 1'b0);
    // R9: clear while freeze line still sensed low is rejected.
    clr[0] = 1'b1; step(); clr[0] = 1'b0;
    chk("R9 directed violation", 0, o_viol[0], 1'b1);
    chk("R9 directed still latched", 0, o_lat[0], 1'b1);
    repeat (3) step();
    chk("R6 directed peer shutdown", 2, o_hsd[2], 1'b1);
    clr[0] = 1'b1; step(); clr[0] = 1'b0;
    chk("R4 directed cleared", 0, o_lat[0], 1'b0);
    // R6: external shutdown is not cleared by flt_clr.
    ext_sd = 1'b1; repeat (3) step();
    clr[1] = 1'b1; step(); clr[1] = 1'b0;
    chk("R6 directed clear no effect", 1, o_hsd[1], 1'b1);
    ext_sd = 1'b0; repeat (4) step();
    // R2: simultaneous trip on both sides picks high side.
    dh[2] = 1'b1; dl[2] = 1'b1; step(); dh[2] = 1'b0; dl[2] = 1'b0;
    chk("R2 directed both sides", 2, o_hi[2], 1'b1);
    repeat (N + 4) step();
    clr[2] = 1'b1; step(); clr[2] = 1'b0;
    repeat (4) step();
    // Random phase.
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NI; i++) begin
        dh[i]  = ($urandom % 50) == 0;
        dl[i]  = ($urandom % 50) == 0;
        clr[i] = ($urandom % 12) == 0;
        if (($urandom % 40) == 0) uv[i] = !uv[i];
      end
      if (($urandom % 60) == 0) ext_sd = !ext_sd;
      if (($urandom % 90) == 0) ext_sync = !ext_sync;
      step();
    end
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule